// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray Pointers and Quadrant Flags

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. Storage is a power-of-two register array. Each side keeps its own position counter. The counter that travels to the other side is held in reflected Gray code, so any two successive values differ in exactly one bit. That single changing bit is what makes a plain per-bit flop chain a safe way to carry the counter across.

On arrival, the other side's Gray counter passes through a chain of synchronizer flops and is then decoded back to binary. It is compared directly against the local binary counter to form the hard flags (full on the producer side, empty on the consumer side). The two soft flags cost almost nothing: they compare only the two top address bits of each counter, which name the quarter of the buffer that the counter currently points into, so no subtractor is needed. Both hard flags are conservative. They clear only after the remote counter has come through the synchronizer, which makes overrun and underrun impossible.

Top module: `afifo_gray_quad`

## Requirements
- R1: While either reset is held, and directly after it, `rd_empty` and `rd_almost_empty` are 1 and `wr_full` and `wr_almost_full` are 0.
- R2: While `rd_empty` is 0, `rd_data` shows the oldest word not yet read. Words come out in the order they were written, with no loss or duplication.
- R3: Once DEPTH words are stored and none has been read, `wr_full` is 1. A write requested while `wr_full` is 1 is dropped and changes neither the stored data nor the write position.
- R4: A read requested while `rd_empty` is 1 is dropped and does not move the read position.
- R5: On every clock edge, each Gray position register changes in at most one bit.
- R6: After a write to an empty FIFO, `rd_empty` stays 1 on the first rising `rd_clk` edge after that write. After a read from a full FIFO, `wr_full` stays 1 on the first rising `wr_clk` edge after that read. Once a few clocks of the receiving domain have passed with no further traffic, each flag clears.
- R7: Take the counts as positions modulo 2*DEPTH. The quadrant of a position is bits [ADDR_W-1:ADDR_W-2] of the address, i.e. (pos mod DEPTH)/(DEPTH/4). Once the counts have settled, `wr_almost_full` is 1 when the FIFO is full or when the read quadrant equals (write quadrant + 1) mod 4. Otherwise it is 0.
- R8: Once the counts have settled, `rd_almost_empty` is 1 when the wrap bits (bit ADDR_W, i.e. (pos / DEPTH) mod 2) of the two positions are equal and both positions lie in the same quadrant. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot, as seen by the producer |
| wr_almost_full | output | 1 | Quadrant-based warning of little free space |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side asynchronous reset, active low |
| rd_en | input | 1 | Read request; takes the word shown on rd_data |
| rd_data | output | DATA_W | Oldest unread word |
| rd_empty | output | 1 | Nothing to read, as seen by the consumer |
| rd_almost_empty | output | 1 | Quadrant-based warning of little stored data |

## Verification
A Gray register that changes two bits at once, or a binary-to-Gray mismatch, corrupts the counter that arrives on the far side. This shows up within a few receiving-clock cycles as a flag that never settles to the value the counts predict, or as words that come out of order. A dropped or extra position step shows up at the next drain, as a missing, repeated or stale `rd_data`. If the synchronizer chain is shortened or bypassed, a flag clears on the very first receiving edge after the remote operation, which the bench samples directly. A wrong quadrant bit or wrap-bit test shows up as soon as the fill sweep reaches a position where the two quadrants are neighbours.

// File: rtl/afq_pkg.sv
`timescale 1ns/1ps
package afq_pkg;
   typedef logic [1:0] quad_t;

   // Quarter of the ring that follows q (wraps 3 -> 0).
   function automatic quad_t quad_next(input quad_t q);
      return q + 2'd1;
   endfunction
endpackage

// File: rtl/afq_gray2bin.sv
`timescale 1ns/1ps
module afq_gray2bin #(
   parameter int W = 5
) (
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);
   // Each binary bit is the XOR of all Gray bits at or above it.
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin_o[i] = ^gray_i[W-1:i];
   end
endmodule

// File: rtl/afq_sync.sv
`timescale 1ns/1ps
module afq_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("afq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/afq_ptr_domain.sv
`timescale 1ns/1ps
module afq_ptr_domain
   import afq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit IS_WRITE    = 1'b1,
   localparam int P          = ADDR_W + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_req,
   input  logic [P-1:0] far_gray_async,
   output logic [P-1:0] own_gray,
   output logic [P-1:0] own_bin,
   output logic [P-1:0] far_bin,
   output logic         stop,
   output logic         near
);
   logic [P-1:0] bin_q, gray_q, bin_nx, far_gray_s;
   logic         step;
   quad_t        own_quad, far_quad;

   afq_sync #(.W(P), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (far_gray_async),
      .d_sync  (far_gray_s)
   );

   afq_gray2bin #(.W(P)) u_g2b (
      .gray_i (far_gray_s),
      .bin_o  (far_bin)
   );

   assign step   = step_req & ~stop;
   assign bin_nx = bin_q + P'(step);

   // Gray value is registered so the crossing starts straight from a flop.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   assign own_quad = bin_q[ADDR_W-1 -: 2];
   assign far_quad = far_bin[ADDR_W-1 -: 2];

   if (IS_WRITE) begin : g_wr_flags
      assign stop = (bin_q[ADDR_W-1:0] == far_bin[ADDR_W-1:0]) &&
                    (bin_q[ADDR_W] != far_bin[ADDR_W]);
      assign near = stop | (far_quad == quad_next(own_quad));
   end else begin : g_rd_flags
      assign stop = (bin_q == far_bin);
      assign near = (bin_q[ADDR_W] == far_bin[ADDR_W]) && (far_quad == own_quad);
   end

   assign own_gray = gray_q;
   assign own_bin  = bin_q;
endmodule

// File: rtl/afq_store.sv
`timescale 1ns/1ps
module afq_store #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_gray_quad.sv
`timescale 1ns/1ps
module afifo_gray_quad #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   output logic              wr_almost_full,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              rd_almost_empty
);
   localparam int P = ADDR_W + 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("afifo_gray_quad: ADDR_W must be at least 2 for quadrant flags");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("afifo_gray_quad: DATA_W must be positive");
   end

   logic [P-1:0] w_gray, r_gray, w_bin, r_bin, w_seen_rbin, r_seen_wbin;

   afq_ptr_domain #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .IS_WRITE(1'b1)) u_wdom (
      .clk            (wr_clk),
      .rst_n          (wr_rst_n),
      .step_req       (wr_en),
      .far_gray_async (r_gray),
      .own_gray       (w_gray),
      .own_bin        (w_bin),
      .far_bin        (w_seen_rbin),
      .stop           (wr_full),
      .near           (wr_almost_full)
   );

   afq_ptr_domain #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .IS_WRITE(1'b0)) u_rdom (
      .clk            (rd_clk),
      .rst_n          (rd_rst_n),
      .step_req       (rd_en),
      .far_gray_async (w_gray),
      .own_gray       (r_gray),
      .own_bin        (r_bin),
      .far_bin        (r_seen_wbin),
      .stop           (rd_empty),
      .near           (rd_almost_empty)
   );

   afq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .wr_clk (wr_clk),
      .we     (wr_en & ~wr_full),
      .waddr  (w_bin[ADDR_W-1:0]),
      .wdata  (wr_data),
      .raddr  (r_bin[ADDR_W-1:0]),
      .rdata  (rd_data)
   );
endmodule

// File: rtl/afq_checker.sv
`timescale 1ns/1ps
module afq_checker #(
   parameter int ADDR_W = 4,
   localparam int P     = ADDR_W + 1,
   localparam int DEPTH = 1 << ADDR_W
) (
   input logic         wr_clk,
   input logic         wr_rst_n,
   input logic         rd_clk,
   input logic         rd_rst_n,
   input logic         wr_en,
   input logic         rd_en,
   input logic         wr_full,
   input logic         rd_empty,
   input logic         wr_almost_full,
   input logic         rd_almost_empty,
   input logic [P-1:0] w_gray,
   input logic [P-1:0] r_gray,
   input logic [P-1:0] w_bin,
   input logic [P-1:0] r_bin,
   input logic [P-1:0] w_seen_rbin,
   input logic [P-1:0] r_seen_wbin
);
   logic [P-1:0] wr_occ, rd_occ;
   assign wr_occ = w_bin - w_seen_rbin;
   assign rd_occ = r_seen_wbin - r_bin;

   AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $onehot0(w_gray ^ $past(w_gray))); // R5
   AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $onehot0(r_gray ^ $past(r_gray))); // R5
   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && wr_full) |=> $stable(w_gray)); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && rd_empty) |=> $stable(r_gray)); // R4
   AST_WR_OCC_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_occ <= P'(DEPTH)); // R3
   AST_RD_OCC_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_occ <= P'(DEPTH)); // R4
   AST_FULL_NEAR: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_full |-> wr_almost_full); // R7
   AST_EMPTY_NEAR: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_empty |-> rd_almost_empty); // R8
endmodule

bind afifo_gray_quad afq_checker #(.ADDR_W(ADDR_W)) u_chk (
   .wr_clk          (wr_clk),
   .wr_rst_n        (wr_rst_n),
   .rd_clk          (rd_clk),
   .rd_rst_n        (rd_rst_n),
   .wr_en           (wr_en),
   .rd_en           (rd_en),
   .wr_full         (wr_full),
   .rd_empty        (rd_empty),
   .wr_almost_full  (wr_almost_full),
   .rd_almost_empty (rd_almost_empty),
   .w_gray          (w_gray),
   .r_gray          (r_gray),
   .w_bin           (w_bin),
   .r_bin           (r_bin),
   .w_seen_rbin     (w_seen_rbin),
   .r_seen_wbin     (r_seen_wbin)
);

// File: tb/afifo_gray_quad_tb.sv
`timescale 1ns/1ps
module afifo_gray_quad_tb;
   localparam int DW = 8;
   localparam int AW = 4;
   localparam int D  = 1 << AW;
   localparam int QS = D / 4;

   logic          wr_clk = 0, rd_clk = 0;
   logic          wr_rst_n = 0, rd_rst_n = 0;
   logic          wr_en = 0, rd_en = 0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          wr_full, wr_almost_full, rd_empty, rd_almost_empty;

   int checks = 0, errors = 0;
   int nw = 0, nr = 0;
   logic [DW-1:0] model [$];
   bit done = 0;

   always #10 wr_clk = ~wr_clk;   // 50 MHz
   always #15 rd_clk = ~rd_clk;

   afifo_gray_quad #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .wr_clk, .wr_rst_n, .wr_en, .wr_data, .wr_full, .wr_almost_full,
      .rd_clk, .rd_rst_n, .rd_en, .rd_data, .rd_empty, .rd_almost_empty
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge wr_clk);
      repeat (6) @(negedge rd_clk);
   endtask

   task automatic push(input logic [DW-1:0] v);
      @(negedge wr_clk);
      wr_en = 1; wr_data = v;
      @(negedge wr_clk);
      wr_en = 0;
      if (nw - nr < D) begin
         model.push_back(v);
         nw++;
      end
   endtask

   task automatic pop(input string req);
      @(negedge rd_clk);
      if (model.size() > 0)
         chk(rd_data == model[0], req, int'(rd_data), int'(model[0]));
      rd_en = 1;
      @(negedge rd_clk);
      rd_en = 0;
      if (model.size() > 0) begin
         void'(model.pop_front());
         nr++;
      end
   endtask

   function automatic bit exp_af();
      int wq = (nw % D) / QS;
      int rq = (nr % D) / QS;
      return (nw - nr == D) || (rq == (wq + 1) % 4);
   endfunction

   function automatic bit exp_ae();
      int wq = (nw % D) / QS;
      int rq = (nr % D) / QS;
      return (((nw / D) % 2) == ((nr / D) % 2)) && (wq == rq);
   endfunction

   task automatic t_reset();
      chk(rd_empty == 1, "R1 rd_empty", rd_empty, 1);
      chk(rd_almost_empty == 1, "R1 rd_almost_empty", rd_almost_empty, 1);
      chk(wr_full == 0, "R1 wr_full", wr_full, 0);
      chk(wr_almost_full == 0, "R1 wr_almost_full", wr_almost_full, 0);
   endtask

   task automatic t_empty_latency();
      @(negedge wr_clk);
      wr_en = 1; wr_data = 8'hA5;
      @(posedge wr_clk); #1;
      wr_en = 0;
      model.push_back(8'hA5); nw++;
      @(posedge rd_clk); #1;
      chk(rd_empty == 1, "R6 empty held", rd_empty, 1);
      settle();
      chk(rd_empty == 0, "R6 empty released", rd_empty, 0);
      pop("R2 single word");
      settle();
      chk(rd_empty == 1, "R2 empty after drain", rd_empty, 1);
   endtask

   task automatic t_underflow();
      // R4: reads on empty are dropped; next word must still come out first
      repeat (3) begin
         @(negedge rd_clk); rd_en = 1;
         @(negedge rd_clk); rd_en = 0;
      end
      push(8'h3C);
      settle();
      chk(rd_empty == 0, "R4 not empty after write", rd_empty, 0);
      chk(rd_data == 8'h3C, "R4 head after dropped reads", rd_data, 8'h3C);
      pop("R4 drain");
      settle();
   endtask

   task automatic t_full_overflow();
      for (int i = 0; i < D; i++) push(8'(8'h40 + i));
      settle();
      chk(wr_full == 1, "R3 full after DEPTH writes", wr_full, 1);
      chk(wr_almost_full == 1, "R7 almost full when full", wr_almost_full, 1);
      push(8'hEE);
      push(8'hEF);
      settle();
      chk(wr_full == 1, "R3 still full", wr_full, 1);
      // R6: release of full is delayed by the synchronizer
      @(negedge rd_clk);
      chk(rd_data == model[0], "R2 head when full", rd_data, model[0]);
      rd_en = 1;
      @(posedge rd_clk); #1;
      rd_en = 0;
      void'(model.pop_front()); nr++;
      @(posedge wr_clk); #1;
      chk(wr_full == 1, "R6 full held", wr_full, 1);
      settle();
      chk(wr_full == 0, "R6 full released", wr_full, 0);
      while (model.size() > 0) pop("R3 drain order, dropped words absent");
      settle();
      chk(rd_empty == 1, "R3 empty after drain", rd_empty, 1);
   endtask

   task automatic t_flag_sweep(input int shift);
      for (int i = 0; i < shift; i++) begin
         push(8'(i));
         settle();
         pop("R2 shift");
      end
      settle();
      for (int k = 0; k <= D; k++) begin
         chk(wr_almost_full == exp_af(), "R7 quadrant almost full", wr_almost_full, exp_af());
         chk(rd_almost_empty == exp_ae(), "R8 quadrant almost empty", rd_almost_empty, exp_ae());
         if (k < D) begin
            push(8'(8'h80 + k + shift));
            settle();
         end
      end
      for (int k = 0; k < D; k++) begin
         pop("R2 sweep drain");
         settle();
         chk(wr_almost_full == exp_af(), "R7 drain almost full", wr_almost_full, exp_af());
         chk(rd_almost_empty == exp_ae(), "R8 drain almost empty", rd_almost_empty, exp_ae());
      end
   endtask

   initial begin
      #5;
      t_reset();
      repeat (3) @(negedge wr_clk);
      wr_rst_n = 1; rd_rst_n = 1;
      settle();
      t_reset();
      t_empty_latency();
      t_underflow();
      t_full_overflow();
      t_flag_sweep(0);
      t_flag_sweep(5);
      t_flag_sweep(7);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule